// File: doc/BRIEF.md
# Memory Port DMA Arbiter

This block sits in front of one single-ported synchronous data memory and decides, cycle by cycle, whether the processor-side request port or the DMA request port drives it. The winner's address, write enable and write data go to the memory. Chip-select is raised when either side requests. The DMA port has strict priority. A processor request that meets an active DMA cycle is stalled and not performed. The processor must hold it and present it again, and it completes in the first cycle after DMA enable drops.

The block also produces the sequential-access hint for the memory. A processor access is flagged sequential only when two conditions hold: its address is one above the last completed processor access, and the previous cycle was itself a processor access. The hint is therefore low in every DMA cycle and low for the first processor access after a steal. The hint is also low for the first processor access after reset.

Read data from the memory arrives one clock after the access. The block hands it back to the requester that owned that cycle, together with a valid flag for that requester only. An idle output reports that the processor side has nothing outstanding.

Top module: `tcm_dma_arbiter`

## Requirements
- R1: When `dma_en_i` is high, `mem_addr_o` equals `dma_addr_i` and `mem_cs_o` is high in that same cycle, whatever the processor side is doing.
- R2: In every cycle with `dma_en_i` high, `mem_seq_o` is low.
- R3: When `cpu_req_i` and `dma_en_i` are both high, `cpu_stall_o` is high and the processor's address, write enable and write data are not on the memory port. In all other cycles `cpu_stall_o` is low.
- R4: A processor request held unchanged after a stall is performed in the first cycle with `dma_en_i` low. In that cycle `mem_cs_o` is high, `mem_addr_o` equals `cpu_addr_i` and `cpu_stall_o` is low.
- R5: The first processor access after one or more DMA cycles has `mem_seq_o` low, even when its address is the last processor address plus one.
- R6: A processor access has `mem_seq_o` high exactly when its address equals the previous completed processor address plus one (modulo 2^AW) and the previous cycle was a performed processor access. Idle cycles and DMA cycles both break the run.
- R7: `cpu_idle_o` is high exactly in cycles where `cpu_req_i` is low.
- R8: `mem_dma_cs_o` is high exactly in cycles where `dma_en_i` is high. `mem_we_o` and `mem_wdata_o` come from the DMA port in those cycles and from the processor port in performed processor cycles.
- R9: One clock after a read by a requester, that requester's valid output (`cpu_rvalid_o` or `dma_rvalid_o`) is high and its data output equals `mem_rdata_i`. The other requester's valid is low. Writes and idle cycles produce no valid.
- R10: While `rst_ni` is low, `mem_cs_o`, `mem_dma_cs_o`, `cpu_stall_o` and both valid outputs are low. Sequence history is cleared, so the first processor access after reset is non-sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request |
| cpu_addr_i | input | AW | Processor address |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_wdata_i | input | DW | Processor write data |
| cpu_stall_o | output | 1 | Processor request not performed this cycle |
| cpu_idle_o | output | 1 | Processor side has no request |
| cpu_rdata_o | output | DW | Read data for processor |
| cpu_rvalid_o | output | 1 | Processor read data valid |
| dma_en_i | input | 1 | DMA access request (strict priority) |
| dma_addr_i | input | AW | DMA address |
| dma_we_i | input | 1 | DMA write enable |
| dma_wdata_i | input | DW | DMA write data |
| dma_rdata_o | output | DW | Read data for DMA |
| dma_rvalid_o | output | 1 | DMA read data valid |
| mem_cs_o | output | 1 | Memory chip-select |
| mem_dma_cs_o | output | 1 | Chip-select qualified as DMA cycle |
| mem_addr_o | output | AW | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | DW | Memory write data |
| mem_seq_o | output | 1 | Sequential-access hint |
| mem_rdata_i | input | DW | Memory read data, one cycle after access |

## Verification
The hardest situation to reach is a steal that lands in the middle of a consecutive processor burst. The replayed access must then drop the sequential hint, and the access after it must raise the hint again. The bench plays a processor model that keeps a stalled request unchanged and otherwise tends to continue bursts. Against it, a pseudo-random DMA stream is swept for a few thousand cycles, so that steals fall at every point of a burst, including back-to-back steals and steals around idle gaps. A directed sequence reproduces the basic replay pattern. A reference model written from the requirements checks every output in every cycle.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DMA  = 2'd2
  } owner_e;
endpackage

// File: rtl/tcm_arb_mux.sv
module tcm_arb_mux
  import tcm_arb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          cpu_req_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic [DW-1:0] cpu_wdata_i,
  input  logic          dma_en_i,
  input  logic [AW-1:0] dma_addr_i,
  input  logic          dma_we_i,
  input  logic [DW-1:0] dma_wdata_i,
  output owner_e        owner_o,
  output logic          mem_cs_o,
  output logic          mem_dma_cs_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          cpu_stall_o
);
  always_comb begin
    if (dma_en_i)       owner_o = OWN_DMA;
    else if (cpu_req_i) owner_o = OWN_CPU;
    else                owner_o = OWN_NONE;
  end

  always_comb begin
    mem_addr_o  = cpu_addr_i;
    mem_we_o    = 1'b0;
    mem_wdata_o = cpu_wdata_i;
    unique case (owner_o)
      OWN_DMA: begin
        mem_addr_o  = dma_addr_i;
        mem_we_o    = dma_we_i;
        mem_wdata_o = dma_wdata_i;
      end
      OWN_CPU: mem_we_o = cpu_we_i;
      default: ;
    endcase
  end

  assign mem_cs_o     = owner_o != OWN_NONE;
  assign mem_dma_cs_o = owner_o == OWN_DMA;
  assign cpu_stall_o  = cpu_req_i && dma_en_i;
endmodule

// File: rtl/tcm_seq_tracker.sv
module tcm_seq_tracker #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_access_i,
  input  logic          dma_access_i,
  input  logic [AW-1:0] cpu_addr_i,
  output logic          seq_o
);
  logic          hist_q;
  logic [AW-1:0] last_q;
  logic [AW-1:0] next_addr;

  assign next_addr = last_q + AW'(1);
  assign seq_o     = cpu_access_i && hist_q && (cpu_addr_i == next_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= 1'b0;
      last_q <= '0;
    end else begin
      // only an immediately preceding processor access keeps the run alive
      hist_q <= cpu_access_i;
      if (cpu_access_i) last_q <= cpu_addr_i;
    end
  end

  p_seq_low_dma_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_access_i |-> !seq_o);
  p_replay_nonseq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dma_access_i) |-> !seq_o);
endmodule

// File: rtl/tcm_rdata_route.sv
module tcm_rdata_route
  import tcm_arb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  owner_e        owner_i,
  input  logic          we_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          cpu_rvalid_o,
  output logic [DW-1:0] dma_rdata_o,
  output logic          dma_rvalid_o
);
  logic cpu_rd_q, dma_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rd_q <= 1'b0;
      dma_rd_q <= 1'b0;
    end else begin
      cpu_rd_q <= (owner_i == OWN_CPU) && !we_i;
      dma_rd_q <= (owner_i == OWN_DMA) && !we_i;
    end
  end

  assign cpu_rvalid_o = cpu_rd_q;
  assign dma_rvalid_o = dma_rd_q;
  assign cpu_rdata_o  = cpu_rd_q ? mem_rdata_i : '0;
  assign dma_rdata_o  = dma_rd_q ? mem_rdata_i : '0;

  p_rvalid_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_rvalid_o && dma_rvalid_o));
  p_cpu_rvalid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_i == OWN_CPU && !we_i) |=> cpu_rvalid_o);
endmodule

// File: rtl/tcm_dma_arbiter.sv
module tcm_dma_arbiter
  import tcm_arb_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_stall_o,
  output logic          cpu_idle_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          cpu_rvalid_o,
  input  logic          dma_en_i,
  input  logic [AW-1:0] dma_addr_i,
  input  logic          dma_we_i,
  input  logic [DW-1:0] dma_wdata_i,
  output logic [DW-1:0] dma_rdata_o,
  output logic          dma_rvalid_o,
  output logic          mem_cs_o,
  output logic          mem_dma_cs_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_seq_o,
  input  logic [DW-1:0] mem_rdata_i
);
  owner_e owner;
  logic   mux_cs, mux_dma_cs, mux_stall;

  tcm_arb_mux #(.AW(AW), .DW(DW)) u_mux (
    .cpu_req_i    (cpu_req_i),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_we_i     (cpu_we_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .dma_en_i     (dma_en_i),
    .dma_addr_i   (dma_addr_i),
    .dma_we_i     (dma_we_i),
    .dma_wdata_i  (dma_wdata_i),
    .owner_o      (owner),
    .mem_cs_o     (mux_cs),
    .mem_dma_cs_o (mux_dma_cs),
    .mem_addr_o   (mem_addr_o),
    .mem_we_o     (mem_we_o),
    .mem_wdata_o  (mem_wdata_o),
    .cpu_stall_o  (mux_stall)
  );

  // outputs quiet while reset is held
  assign mem_cs_o     = rst_ni && mux_cs;
  assign mem_dma_cs_o = rst_ni && mux_dma_cs;
  assign cpu_stall_o  = rst_ni && mux_stall;
  assign cpu_idle_o   = !cpu_req_i;

  tcm_seq_tracker #(.AW(AW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_access_i (owner == OWN_CPU),
    .dma_access_i (owner == OWN_DMA),
    .cpu_addr_i   (cpu_addr_i),
    .seq_o        (mem_seq_o)
  );

  tcm_rdata_route #(.DW(DW)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .owner_i      (owner),
    .we_i         (mem_we_o),
    .mem_rdata_i  (mem_rdata_i),
    .cpu_rdata_o  (cpu_rdata_o),
    .cpu_rvalid_o (cpu_rvalid_o),
    .dma_rdata_o  (dma_rdata_o),
    .dma_rvalid_o (dma_rvalid_o)
  );

  p_dma_addr_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_en_i |-> (mem_cs_o && mem_addr_o == dma_addr_i));
  p_stall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_stall_o |-> (mem_dma_cs_o && cpu_req_i));
  p_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_idle_o |-> !cpu_stall_o);
  p_dma_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dma_cs_o == dma_en_i);
endmodule

// File: tb/tcm_dma_arbiter_test.sv
module tcm_dma_arbiter_test;
  localparam int AW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0, dma_en = 0, dma_we = 0;
  logic [AW-1:0] cpu_addr = '0, dma_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, dma_wdata = '0;
  logic          cpu_stall, cpu_idle, cpu_rvalid, dma_rvalid;
  logic [DW-1:0] cpu_rdata, dma_rdata, mem_wdata;
  logic          mem_cs, mem_dma_cs, mem_we, mem_seq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;

  tcm_dma_arbiter #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr), .cpu_we_i(cpu_we), .cpu_wdata_i(cpu_wdata),
    .cpu_stall_o(cpu_stall), .cpu_idle_o(cpu_idle), .cpu_rdata_o(cpu_rdata), .cpu_rvalid_o(cpu_rvalid),
    .dma_en_i(dma_en), .dma_addr_i(dma_addr), .dma_we_i(dma_we), .dma_wdata_i(dma_wdata),
    .dma_rdata_o(dma_rdata), .dma_rvalid_o(dma_rvalid),
    .mem_cs_o(mem_cs), .mem_dma_cs_o(mem_dma_cs), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_seq_o(mem_seq), .mem_rdata_i(mem_rdata)
  );

  function automatic logic [DW-1:0] mem_fn(input logic [AW-1:0] a);
    return {a, ~a} ^ 16'h5a3c;
  endfunction

  // synchronous memory read model
  always @(posedge clk) if (mem_cs && !mem_we) mem_rdata <= mem_fn(mem_addr);

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model state
  bit            m_hist = 0;
  logic [AW-1:0] m_last = '0;
  bit            m_cpu_rd = 0, m_dma_rd = 0;
  logic [AW-1:0] m_rd_addr = '0;

  task automatic step(input bit req, input logic [AW-1:0] a, input bit we,
                      input bit den, input logic [AW-1:0] da, input bit dwe);
    bit cpu_acc, exp_seq;
    @(negedge clk);
    cpu_req = req; cpu_addr = a; cpu_we = we; cpu_wdata = {a, 8'h11};
    dma_en = den; dma_addr = da; dma_we = dwe; dma_wdata = {da, 8'hd3};
    #1;
    cpu_acc = req && !den;
    exp_seq = cpu_acc && m_hist && (a == m_last + 8'd1);
    chk(cpu_idle == !req, "R7 idle", cpu_idle, !req);
    chk(cpu_stall == (req && den), "R3 stall", cpu_stall, req && den);
    chk(mem_cs == (req || den), "R1/R4 cs", mem_cs, req || den);
    chk(mem_dma_cs == den, "R8 dma_cs", mem_dma_cs, den);
    chk(mem_seq == exp_seq, den ? "R2 seq" : (m_hist ? "R6 seq" : "R5 seq"), mem_seq, exp_seq);
    if (den) begin
      chk(mem_addr == da, "R1 addr", mem_addr, da);
      chk(mem_we == dwe && mem_wdata == {da, 8'hd3}, "R8/R3 dma we/wdata", mem_wdata, {da, 8'hd3});
    end else if (req) begin
      chk(mem_addr == a, "R4 addr", mem_addr, a);
      chk(mem_we == we && mem_wdata == {a, 8'h11}, "R8 cpu we/wdata", mem_wdata, {a, 8'h11});
    end
    chk(cpu_rvalid == m_cpu_rd, "R9 cpu_rvalid", cpu_rvalid, m_cpu_rd);
    chk(dma_rvalid == m_dma_rd, "R9 dma_rvalid", dma_rvalid, m_dma_rd);
    if (m_cpu_rd) chk(cpu_rdata == mem_fn(m_rd_addr), "R9 cpu_rdata", cpu_rdata, mem_fn(m_rd_addr));
    if (m_dma_rd) chk(dma_rdata == mem_fn(m_rd_addr), "R9 dma_rdata", dma_rdata, mem_fn(m_rd_addr));
    @(posedge clk);
    m_hist = cpu_acc;
    if (cpu_acc) m_last = a;
    m_cpu_rd = cpu_acc && !we;
    m_dma_rd = den && !dwe;
    m_rd_addr = den ? da : a;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    bit          p_req, p_we;
    logic [AW-1:0] p_addr;
    // R10: reset state with both sides requesting
    cpu_req = 1; dma_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!mem_cs && !mem_dma_cs && !cpu_stall, "R10 reset outputs", {mem_cs, mem_dma_cs, cpu_stall}, 0);
    chk(!cpu_rvalid && !dma_rvalid, "R10 reset rvalid", {cpu_rvalid, dma_rvalid}, 0);
    cpu_req = 0; dma_en = 0;
    rst_n = 1;
    // R10: first access at last+1 of cleared history is non-sequential
    step(1, 8'd1, 0, 0, 0, 0);
    chk(m_hist, "R10 first access done", 0, 1);
    // directed steal inside a burst (R4, R5, R6)
    step(0, 8'h00, 0, 1, 8'hA0, 0);
    step(1, 8'h40, 0, 0, 0, 0);
    step(1, 8'h41, 0, 0, 0, 0);
    step(1, 8'h42, 0, 1, 8'hC0, 0);
    step(1, 8'h42, 0, 0, 0, 0);
    step(1, 8'h43, 0, 0, 0, 0);
    // sweep with a processor model that replays stalled requests
    lfsr = 16'hACE1; p_req = 0; p_addr = '0; p_we = 0;
    for (int i = 0; i < 4000; i++) begin
      bit den, stalled;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      den = lfsr[2] & lfsr[7];
      stalled = p_req && dma_en;
      if (!stalled) begin
        p_req = lfsr[0] | lfsr[5];
        p_addr = (lfsr[9:8] != 2'b00) ? p_addr + 8'd1 : lfsr[15:8];
        p_we = lfsr[4] & lfsr[11];
      end
      step(p_req, p_addr, p_we, den, lfsr[12:5], lfsr[3] & lfsr[14]);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule